// File: doc/BRIEF.md
# SDRAM Write Burst Column Sequencer

This block is the device-side write path of a synchronous DRAM model. It watches a decoded command stream and, when a write command arrives, turns one command into a burst of array writes. Each cycle of an active burst it issues one write strobe with a bank, a column and the data word present on the input bus that cycle. The column steps sequentially, wrapping inside an aligned block for fixed lengths and around the whole row for full-page bursts.

A burst ends in one of four ways. It can reach its programmed length. A later write command can cut it short. A terminate command can stop it. A reset can clear it. When a burst opened with auto precharge runs to its natural end, the block raises a precharge request for that bank together with the final write strobe. The write strobe, address, data and precharge outputs feed a simple behavioural storage array and a row controller.

Top module: `wburst_seq`

## Requirements
- R1: A write command (cmd_i = 1) is itself a data cycle. One cycle later wr_en_o is high, with wr_bank_o and wr_col_o equal to the command's bank and column and wr_data_o equal to din_i from the command cycle.
- R2: On each cycle after the command while the burst runs, one more word is written. The column advances by one modulo the burst length inside the aligned block given by the low column bits: lengths 2, 4 and 8 use 1, 2 and 3 bits.
- R3: A full-page burst (blen_i = 7) advances through all 256 columns, wraps from 255 to 0, and never stops on its own.
- R4: Once a fixed-length burst has written its last word, later data is ignored. No strobe is issued until a new write command arrives.
- R5: When a burst opened with ap_i high writes its final word, pre_req_o is high in the same cycle as that word's strobe, and wr_bank_o names the bank. A full-page burst never raises it.
- R6: A write command during a running burst ends that burst at once. That cycle's data goes to the new command's address. The cut burst raises no precharge request.
- R7: A new write command may follow the last word of a fixed burst with no idle cycle, and its strobes continue back to back.
- R8: A terminate command (cmd_i = 2) during a burst writes nothing for that cycle, ends the burst and raises no precharge request. When no burst is running it has no effect.
- R9: The burst length code blen_i is sampled with the write command: 0 means 1 word, 1 means 2, 2 means 4, 3 means 8, 7 means full page, and any other code means 1 word. Command codes 0 and 3 are no-operation.
- R10: While rst_n is low, wr_en_o and pre_req_o are low, the address and data outputs are zero, and any running burst is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 2 | Decoded command: 0 no-op, 1 write, 2 terminate, 3 no-op |
| bank_i | input | 2 | Bank address, sampled with a write |
| col_i | input | 8 | Starting column, sampled with a write |
| ap_i | input | 1 | Auto-precharge enable, sampled with a write |
| blen_i | input | 3 | Burst length code, sampled with a write |
| din_i | input | 16 | Data word for the current cycle |
| wr_en_o | output | 1 | Array write strobe |
| wr_bank_o | output | 2 | Bank of the write |
| wr_col_o | output | 8 | Column of the write |
| wr_data_o | output | 16 | Data of the write |
| pre_req_o | output | 1 | Precharge request for wr_bank_o, coinciding with the last word |

## Verification
Every result of this block appears exactly one clock after the input cycle that causes it. This holds for the strobe, the address, the data and the precharge flag, whether the cycle carries a write command, a continuation word or a terminate. The bench drives each input step on a falling edge and compares the outputs on the next falling edge, after the single register stage has loaded, so each table row's expected values describe the cycle right after its own stimulus. Reset is the one exception: it acts at once, and its check is made while it is still held low.

// File: rtl/wb_pkg.sv
package wb_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_TERM  = 2'd2,
    CMD_RSVD  = 2'd3
  } wb_cmd_e;

  localparam logic [2:0] BLC_1    = 3'd0;
  localparam logic [2:0] BLC_2    = 3'd1;
  localparam logic [2:0] BLC_4    = 3'd2;
  localparam logic [2:0] BLC_8    = 3'd3;
  localparam logic [2:0] BLC_PAGE = 3'd7;
endpackage

// File: rtl/wb_colgen.sv
// Next column inside a wrap block: bits under the mask count up, the others hold.
module wb_colgen #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] mask_i,
  output logic [COL_W-1:0] nxt_o
);
  logic [COL_W-1:0] inc;
  assign inc = col_i + COL_W'(1);

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign nxt_o[b] = mask_i[b] ? inc[b] : col_i[b];
  end
endmodule

// File: rtl/wb_ctrl.sv
module wb_ctrl
  import wb_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  parameter int MAX_BL = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              ap_i,
  input  logic [2:0]        blen_i,
  output logic              fire_o,
  output logic [BANK_W-1:0] fire_bank_o,
  output logic [COL_W-1:0]  fire_col_o,
  output logic              fire_pre_o
);
  localparam int CNT_W = $clog2(MAX_BL);

  wb_cmd_e cmd;
  assign cmd = wb_cmd_e'(cmd_i);

  logic              act_q, act_n;
  logic [BANK_W-1:0] bank_q, bank_n;
  logic [COL_W-1:0]  col_q, col_n;
  logic [CNT_W-1:0]  left_q, left_n;
  logic [COL_W-1:0]  mask_q, mask_n;
  logic              ap_q, ap_n;
  logic              page_q, page_n;

  // Decode of the length code presented with a write
  logic [CNT_W-1:0] new_left;
  logic             new_page;
  always_comb begin
    new_page = 1'b0;
    unique case (blen_i)
      BLC_2:    new_left = CNT_W'(1);
      BLC_4:    new_left = CNT_W'(3);
      BLC_8:    new_left = CNT_W'(7);
      BLC_PAGE: begin new_left = '0; new_page = 1'b1; end
      default:  new_left = '0;
    endcase
  end

  logic             is_wr;
  logic [COL_W-1:0] sel_mask, nxt_col;
  assign is_wr    = (cmd == CMD_WRITE);
  assign sel_mask = is_wr ? (new_page ? '1 : COL_W'(new_left)) : mask_q;

  wb_colgen #(.COL_W(COL_W)) u_colgen (
    .col_i  (fire_col_o),
    .mask_i (sel_mask),
    .nxt_o  (nxt_col)
  );

  always_comb begin
    act_n  = act_q;
    bank_n = bank_q;
    col_n  = col_q;
    left_n = left_q;
    mask_n = mask_q;
    ap_n   = ap_q;
    page_n = page_q;
    fire_o      = 1'b0;
    fire_pre_o  = 1'b0;
    fire_bank_o = bank_q;
    fire_col_o  = col_q;
    if (is_wr) begin
      fire_o      = 1'b1;
      fire_bank_o = bank_i;
      fire_col_o  = col_i;
      bank_n      = bank_i;
      col_n       = nxt_col;
      left_n      = new_left;
      mask_n      = sel_mask;
      ap_n        = ap_i;
      page_n      = new_page;
      act_n       = new_page || (new_left != '0);
      fire_pre_o  = ap_i && !new_page && (new_left == '0);
    end else if (act_q) begin
      if (cmd == CMD_TERM) begin
        act_n = 1'b0;
      end else begin
        fire_o = 1'b1;
        col_n  = nxt_col;
        if (!page_q) begin
          left_n = left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) begin
            act_n      = 1'b0;
            fire_pre_o = ap_q;
          end
        end
      end
    end
  end

  logic upd;
  assign upd = is_wr || act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      bank_q <= '0;
      col_q  <= '0;
      left_q <= '0;
      mask_q <= '0;
      ap_q   <= 1'b0;
      page_q <= 1'b0;
    end else if (upd) begin
      act_q  <= act_n;
      bank_q <= bank_n;
      col_q  <= col_n;
      left_q <= left_n;
      mask_q <= mask_n;
      ap_q   <= ap_n;
      page_q <= page_n;
    end
  end
endmodule

// File: rtl/wb_outreg.sv
module wb_outreg #(
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pre_i,
  output logic              wr_en_o,
  output logic [BANK_W-1:0] wr_bank_o,
  output logic [COL_W-1:0]  wr_col_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              pre_req_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_o   <= 1'b0;
      pre_req_o <= 1'b0;
    end else begin
      wr_en_o   <= fire_i;
      pre_req_o <= pre_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bank_o <= '0;
      wr_col_o  <= '0;
      wr_data_o <= '0;
    end else if (fire_i) begin
      wr_bank_o <= bank_i;
      wr_col_o  <= col_i;
      wr_data_o <= data_i;
    end
  end
endmodule

// File: rtl/wburst_seq.sv
module wburst_seq #(
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16,
  parameter int MAX_BL = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              ap_i,
  input  logic [2:0]        blen_i,
  input  logic [DATA_W-1:0] din_i,
  output logic              wr_en_o,
  output logic [BANK_W-1:0] wr_bank_o,
  output logic [COL_W-1:0]  wr_col_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              pre_req_o
);
  logic              fire, fire_pre;
  logic [BANK_W-1:0] fire_bank;
  logic [COL_W-1:0]  fire_col;

  wb_ctrl #(.BANK_W(BANK_W), .COL_W(COL_W), .MAX_BL(MAX_BL)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd_i),
    .bank_i      (bank_i),
    .col_i       (col_i),
    .ap_i        (ap_i),
    .blen_i      (blen_i),
    .fire_o      (fire),
    .fire_bank_o (fire_bank),
    .fire_col_o  (fire_col),
    .fire_pre_o  (fire_pre)
  );

  wb_outreg #(.BANK_W(BANK_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_i    (fire),
    .bank_i    (fire_bank),
    .col_i     (fire_col),
    .data_i    (din_i),
    .pre_i     (fire_pre),
    .wr_en_o   (wr_en_o),
    .wr_bank_o (wr_bank_o),
    .wr_col_o  (wr_col_o),
    .wr_data_o (wr_data_o),
    .pre_req_o (pre_req_o)
  );
endmodule

// File: rtl/wburst_seq_chk.sv
module wburst_seq_chk
  import wb_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cmd_i,
  input logic [BANK_W-1:0] bank_i,
  input logic [COL_W-1:0]  col_i,
  input logic [DATA_W-1:0] din_i,
  input logic              wr_en_o,
  input logic [BANK_W-1:0] wr_bank_o,
  input logic [COL_W-1:0]  wr_col_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              pre_req_o
);
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i == CMD_WRITE |=> wr_en_o && wr_bank_o == $past(bank_i) &&
      wr_col_o == $past(col_i) && wr_data_o == $past(din_i)); // R1

  AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o && cmd_i != CMD_WRITE && cmd_i != CMD_TERM |=>
      !wr_en_o || (wr_bank_o == $past(wr_bank_o) && wr_col_o[0] != $past(wr_col_o[0]))); // R2

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_o && cmd_i != CMD_WRITE |=> !wr_en_o); // R4

  AST_PRE_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    pre_req_o |-> wr_en_o); // R5

  AST_TERM_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i == CMD_TERM |=> !wr_en_o && !pre_req_o); // R8
endmodule

bind wburst_seq wburst_seq_chk #(.BANK_W(BANK_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_i     (cmd_i),
  .bank_i    (bank_i),
  .col_i     (col_i),
  .din_i     (din_i),
  .wr_en_o   (wr_en_o),
  .wr_bank_o (wr_bank_o),
  .wr_col_o  (wr_col_o),
  .wr_data_o (wr_data_o),
  .pre_req_o (pre_req_o)
);

// File: tb/wburst_seq_test.sv
module wburst_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSTEP = 36;

  typedef struct packed {
    logic [1:0]  cmd;
    logic [1:0]  bank;
    logic [7:0]  col;
    logic        ap;
    logic [2:0]  bl;
    logic [15:0] din;
    logic        e_en;
    logic [1:0]  e_bank;
    logic [7:0]  e_col;
    logic        e_pre;
    logic [3:0]  req;
  } step_t;

  // Each row: stimulus, then outputs expected one clock later.
  localparam step_t VEC [NSTEP] = '{
    '{2'd1, 2'd1, 8'h05, 1'b0, 3'd2, 16'hA001, 1'b1, 2'd1, 8'h05, 1'b0, 4'd1},  // R1 BL4 start
    '{2'd0, 2'd0, 8'h00, 1'b0, 3'd0, 16'hA002, 1'b1, 2'd1, 8'h06, 1'b0, 4'd2},
    '{2'd0, 2'd0, 8'h00, 1'b0, 3'd0, 16'hA003, 1'b1, 2'd1, 8'h07, 1'b0, 4'd2},
    '{2'd0, 2'd0, 8'h00, 1'b0, 3'd0, 16'hA004, 1'b1, 2'd1, 8'h04, 1'b0, 4'd2},  // R2 wrap in block
    '{2'd0, 2'd0, 8'h00, 1'b0, 3'd0, 16'hA005, 1'b0, 2'd0, 8'h00, 1'b0, 4'd4},  // R4 ignored
    '{2'd1, 2'd2, 8'h0E, 1'b1, 3'd1, 16'hB001, 1'b1, 2'd2, 8'h0E, 1'b0, 4'd9},  // R9 BL2
    '{2'd0, 2'd0, 8'h00, 1'b0, 3'd0, 16'hB002, 1'b1, 2'd2, 8'h0F, 1'b1, 4'd5},  // R5 precharge
    '{2'd1, 2'd0, 8'h3A, 1'b0, 3'd3, 16'hC001, 1'b1, 2'd0, 8'h3A, 1'b0, 4'd7},  // R7 back to back
    '{2'd0, 2'd0, 8'h00, 1'b0, 3'd0, 16'hC002, 1'b1, 2'd0, 8'h3B, 1'b0, 4'd2},
    '{2'd1, 2'd3, 8'h10, 1'b1, 3'd0, 16'hD001, 1'b1, 2'd3, 8'h10, 1'b1, 4'd6},  // R6 cut by BL1
    '{2'd0, 2'd0, 8'h00, 1'b0, 3'd0, 16'hD002, 1'b0, 2'd0, 8'h00, 1'b0, 4'd4},
    '{2'd1, 2'd1, 8'hFE, 1'b1, 3'd7, 16'hE001, 1'b1, 2'd1, 8'hFE, 1'b0, 4'd3},  // R3 full page
    '{2'd0, 2'd0, 8'h00, 1'b0, 3'd0, 16'hE002, 1'b1, 2'd1, 8'hFF, 1'b0, 4'd3},
    '{2'd0, 2'd0, 8'h00, 1'b0, 3'd0, 16'hE003, 1'b1, 2'd1, 8'h00, 1'b0, 4'd3},  // R3 wrap to 0
    '{2'd3, 2'd0, 8'h00, 1'b0, 3'd0, 16'hE004, 1'b1, 2'd1, 8'h01, 1'b0, 4'd9},  // R9 code 3 no-op
    '{2'd2, 2'd0, 8'h00, 1'b0, 3'd0, 16'hE005, 1'b0, 2'd0, 8'h00, 1'b0, 4'd8},  // R8 terminate
    '{2'd0, 2'd0, 8'h00, 1'b0, 3'd0, 16'hE006, 1'b0, 2'd0, 8'h00, 1'b0, 4'd8},
    '{2'd1, 2'd0, 8'h21, 1'b1, 3'd2, 16'hF001, 1'b1, 2'd0, 8'h21, 1'b0, 4'd1},
    '{2'd0, 2'd0, 8'h00, 1'b0, 3'd0, 16'hF002, 1'b1, 2'd0, 8'h22, 1'b0, 4'd2},
    '{2'd1, 2'd0, 8'h40, 1'b1, 3'd1, 16'hF003, 1'b1, 2'd0, 8'h40, 1'b0, 4'd6},  // R6 no pre for cut
    '{2'd0, 2'd0, 8'h00, 1'b0, 3'd0, 16'hF004, 1'b1, 2'd0, 8'h41, 1'b1, 4'd5},
    '{2'd1, 2'd2, 8'h80, 1'b0, 3'd1, 16'h9001, 1'b1, 2'd2, 8'h80, 1'b0, 4'd7},
    '{2'd0, 2'd0, 8'h00, 1'b0, 3'd0, 16'h9002, 1'b1, 2'd2, 8'h81, 1'b0, 4'd7},
    '{2'd1, 2'd1, 8'h33, 1'b1, 3'd5, 16'h8001, 1'b1, 2'd1, 8'h33, 1'b1, 4'd9},  // R9 odd code
    '{2'd0, 2'd0, 8'h00, 1'b0, 3'd0, 16'h8002, 1'b0, 2'd0, 8'h00, 1'b0, 4'd9},
    '{2'd1, 2'd3, 8'h7D, 1'b1, 3'd3, 16'h7001, 1'b1, 2'd3, 8'h7D, 1'b0, 4'd2},  // R2 BL8
    '{2'd0, 2'd0, 8'h00, 1'b0, 3'd0, 16'h7002, 1'b1, 2'd3, 8'h7E, 1'b0, 4'd2},
    '{2'd0, 2'd0, 8'h00, 1'b0, 3'd0, 16'h7003, 1'b1, 2'd3, 8'h7F, 1'b0, 4'd2},
    '{2'd0, 2'd0, 8'h00, 1'b0, 3'd0, 16'h7004, 1'b1, 2'd3, 8'h78, 1'b0, 4'd2},
    '{2'd0, 2'd0, 8'h00, 1'b0, 3'd0, 16'h7005, 1'b1, 2'd3, 8'h79, 1'b0, 4'd2},
    '{2'd0, 2'd0, 8'h00, 1'b0, 3'd0, 16'h7006, 1'b1, 2'd3, 8'h7A, 1'b0, 4'd2},
    '{2'd0, 2'd0, 8'h00, 1'b0, 3'd0, 16'h7007, 1'b1, 2'd3, 8'h7B, 1'b0, 4'd2},
    '{2'd0, 2'd0, 8'h00, 1'b0, 3'd0, 16'h7008, 1'b1, 2'd3, 8'h7C, 1'b1, 4'd5},
    '{2'd0, 2'd0, 8'h00, 1'b0, 3'd0, 16'h7009, 1'b0, 2'd0, 8'h00, 1'b0, 4'd4},
    '{2'd2, 2'd0, 8'h00, 1'b0, 3'd0, 16'h700A, 1'b0, 2'd0, 8'h00, 1'b0, 4'd8},  // R8 idle
    '{2'd0, 2'd0, 8'h00, 1'b0, 3'd0, 16'h700B, 1'b0, 2'd0, 8'h00, 1'b0, 4'd8}
  };

  logic        clk, rst_n;
  logic [1:0]  cmd_i, bank_i;
  logic [7:0]  col_i;
  logic        ap_i;
  logic [2:0]  blen_i;
  logic [15:0] din_i;
  logic        wr_en_o, pre_req_o;
  logic [1:0]  wr_bank_o;
  logic [7:0]  wr_col_o;
  logic [15:0] wr_data_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  wburst_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i), .col_i(col_i),
    .ap_i(ap_i), .blen_i(blen_i), .din_i(din_i), .wr_en_o(wr_en_o),
    .wr_bank_o(wr_bank_o), .wr_col_o(wr_col_o), .wr_data_o(wr_data_o),
    .pre_req_o(pre_req_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] c, input logic [1:0] b, input logic [7:0] co,
                       input logic a, input logic [2:0] l, input logic [15:0] d);
    cmd_i = c; bank_i = b; col_i = co; ap_i = a; blen_i = l; din_i = d;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    drive(2'd0, 2'd0, 8'h00, 1'b0, 3'd0, 16'h0000);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 en", {31'd0, wr_en_o}, 32'd0);
    check("R10 pre", {31'd0, pre_req_o}, 32'd0);
    check("R10 addr/data", {6'd0, wr_bank_o, wr_col_o, wr_data_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NSTEP; i++) begin
      string tag;
      drive(VEC[i].cmd, VEC[i].bank, VEC[i].col, VEC[i].ap, VEC[i].bl, VEC[i].din);
      @(negedge clk);
      tag = $sformatf("R%0d step %0d", VEC[i].req, i);
      check({tag, " en"}, {31'd0, wr_en_o}, {31'd0, VEC[i].e_en});
      check({tag, " pre"}, {31'd0, pre_req_o}, {31'd0, VEC[i].e_pre});
      if (VEC[i].e_en) begin
        check({tag, " bank"}, {30'd0, wr_bank_o}, {30'd0, VEC[i].e_bank});
        check({tag, " col"}, {24'd0, wr_col_o}, {24'd0, VEC[i].e_col});
        check({tag, " data"}, {16'd0, wr_data_o}, {16'd0, VEC[i].din});
      end
    end

    // R10 reset in the middle of a full-page burst
    drive(2'd1, 2'd2, 8'h10, 1'b0, 3'd7, 16'h5501);
    @(negedge clk);
    drive(2'd0, 2'd0, 8'h00, 1'b0, 3'd0, 16'h5502);
    @(negedge clk);
    check("R3 page runs", {24'd0, wr_col_o}, 32'h11);
    #1 rst_n = 1'b0;
    #1;
    check("R10 async clear en", {31'd0, wr_en_o}, 32'd0);
    check("R10 async clear col", {24'd0, wr_col_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 burst discarded", {31'd0, wr_en_o}, 32'd0);
    @(negedge clk);
    check("R10 burst discarded later", {31'd0, wr_en_o}, 32'd0);

    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule